// File: doc/BRIEF.md
# Asynchronous Memory Fault Logger

This block records errors that the memory system reports apart from the instruction stream, and it raises the trap or reset request that each error needs. Each clock cycle it samples a vector of error events, one bit for each error class. Alongside the vector come a physical address, an ECC syndrome, a parity syndrome, a flag that tells an instruction fetch from a data access, and the privilege level of the access. Every class has its own fixed rules. These rules say whether the address is kept, which syndrome is kept, whether privilege is recorded, and what kind of trap or reset follows.

Two software-visible registers hold the results: a fault address register and a fault status register. Software reads both through a small register port. It clears non-fatal status bits by writing ones to them, and it may also write the address register. Each error keeps its address, its syndromes and its privilege bit until software clears the status bits that caused the capture, so the first fault is the one that is kept. The two fatal classes ask the system for a power-on reset, and only reset clears their status bits.

Top module: `async_fault_log`

## Requirements
- R1: Reading the address register (reg_sel=1) returns the captured physical address bits 40:4 in positions 40:4, with bits 63:41 and 3:0 read as zero. A software write to the address register changes only bits 40:4.
- R2: An uncorrectable ECC event (vector bit 0) does four things: it captures the address, keeps the ECC syndrome, records privilege and sets status bit 0. It also pulses trap_instr_err when evt_instr=1 and trap_data_err when evt_instr=0.
- R3: A correctable ECC event (bit 1) captures the address and keeps the ECC syndrome, sets status bit 1 and pulses trap_corr_err. It leaves the privilege bit unchanged.
- R4: An external-cache load/fetch parity event (bit 2) and an interconnect-buffer return parity event (bit 5) each keep the parity syndrome, record privilege and pulse the instruction or data trap chosen by evt_instr. They set status bit 2 or 5 and leave the address register unchanged.
- R5: A writeback parity event (bit 3) sets status bit 3, keeps the parity syndrome and pulses trap_data_err whatever the value of evt_instr. It leaves privilege unchanged. A copyout parity event (bit 4) sets status bit 4 and keeps the parity syndrome, but it pulses no trap output.
- R6: A bus error (bit 6) or a time-out (bit 7) captures the address, records privilege, sets its status bit and pulses the instruction or data trap. Both syndrome fields stay unchanged.
- R7: An interrupt vector carrying an uncorrectable error (bit 8) sets status bit 8 and records privilege. It always pulses trap_data_err and never trap_instr_err, and it leaves the address unchanged.
- R8: A tag parity event (bit 9, which also keeps the parity syndrome) or an incoming address parity event (bit 10) sets its status bit and pulses por_req. A software write of one to either bit does not clear it; only reset does.
- R9: The address register is not overwritten while status bit 0, 1, 6 or 7 is set. The ECC syndrome is not overwritten while bit 0 or 1 is set. The parity syndrome is not overwritten while bit 2, 3, 4, 5 or 9 is set. The privilege bit is not overwritten while bit 0, 2, 5, 6, 7 or 8 is set.
- R10: Reading the status register (reg_sel=0) returns the status bits in 10:0, privilege in bit 11, the ECC syndrome in 19:12, the parity syndrome in 23:20 and zeros above. Writing it clears each of bits 8:0 where the written data has a one. An event that arrives in the same cycle as the write keeps its bit set.
- R11: Each trap and reset output is high for exactly the one cycle after the clock edge that samples its event, and all outputs and registers read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the power-on clear |
| evt_vec | input | 11 | One bit per error class, sampled each cycle |
| evt_pa | input | 41 | Physical address of the faulting access |
| evt_esynd | input | 8 | ECC syndrome of the event |
| evt_psynd | input | 4 | Parity syndrome of the event |
| evt_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| evt_priv | input | 1 | Privilege level of the access |
| reg_sel | input | 1 | 0 = status register, 1 = address register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| trap_instr_err | output | 1 | Instruction access error trap pulse |
| trap_data_err | output | 1 | Data access error trap pulse |
| trap_corr_err | output | 1 | Corrected ECC error trap pulse |
| por_req | output | 1 | Power-on reset request pulse |

## Verification
A software write that clears a status bit can fall in the same clock cycle as a new event of the same class. An event can also arrive in the same cycle as a software write to the address register. The bench drives the write strobe and the event vector together on one edge. It then reads both registers back. The same-class status bit must stay set, any other bit named in the write must clear, and the captured address must win over the written value.

// File: rtl/afl_pkg.sv
// Package for the fault logger: class indices, the per-class rule table
// and the masks derived from it. Assumes one vector bit per error class.
package afl_pkg;

    localparam int NCLS   = 11;
    localparam int C_UE   = 0;
    localparam int C_CE   = 1;
    localparam int C_EDP  = 2;
    localparam int C_WBP  = 3;
    localparam int C_CPP  = 4;
    localparam int C_BUFP = 5;
    localparam int C_BERR = 6;
    localparam int C_TOUT = 7;
    localparam int C_IVUE = 8;
    localparam int C_TAGP = 9;
    localparam int C_SAP  = 10;

    typedef enum logic [2:0] {
        TK_NONE,
        TK_DEFER_ID,
        TK_DEFER_D,
        TK_DISRUPT_D,
        TK_DISRUPT_C,
        TK_FATAL
    } trap_kind_e;

    typedef struct packed {
        logic       cap_pa;
        logic       keep_e;
        logic       keep_p;
        logic       log_priv;
        trap_kind_e kind;
    } rule_t;

    // Fixed handling rules of one error class
    function automatic rule_t rule_of(input int idx);
        rule_t r;
        case (idx)
            C_UE:    r = '{1'b1, 1'b1, 1'b0, 1'b1, TK_DEFER_ID};
            C_CE:    r = '{1'b1, 1'b1, 1'b0, 1'b0, TK_DISRUPT_C};
            C_EDP:   r = '{1'b0, 1'b0, 1'b1, 1'b1, TK_DEFER_ID};
            C_WBP:   r = '{1'b0, 1'b0, 1'b1, 1'b0, TK_DISRUPT_D};
            C_CPP:   r = '{1'b0, 1'b0, 1'b1, 1'b0, TK_NONE};
            C_BUFP:  r = '{1'b0, 1'b0, 1'b1, 1'b1, TK_DEFER_ID};
            C_BERR:  r = '{1'b1, 1'b0, 1'b0, 1'b1, TK_DEFER_ID};
            C_TOUT:  r = '{1'b1, 1'b0, 1'b0, 1'b1, TK_DEFER_ID};
            C_IVUE:  r = '{1'b0, 1'b0, 1'b0, 1'b1, TK_DEFER_D};
            C_TAGP:  r = '{1'b0, 1'b0, 1'b1, 1'b0, TK_FATAL};
            C_SAP:   r = '{1'b0, 1'b0, 1'b0, 1'b0, TK_FATAL};
            default: r = '{1'b0, 1'b0, 1'b0, 1'b0, TK_NONE};
        endcase
        return r;
    endfunction

    // Mask of classes whose rule sets a chosen field (0 pa, 1 esynd, 2 psynd, 3 priv)
    function automatic logic [NCLS-1:0] mask_of(input int field);
        logic [NCLS-1:0] m;
        rule_t           r;
        m = '0;
        for (int i = 0; i < NCLS; i++) begin
            r = rule_of(i);
            case (field)
                0:       m[i] = r.cap_pa;
                1:       m[i] = r.keep_e;
                2:       m[i] = r.keep_p;
                default: m[i] = r.log_priv;
            endcase
        end
        return m;
    endfunction

    // Mask of classes whose status software may clear
    function automatic logic [NCLS-1:0] sw_clear_mask();
        logic [NCLS-1:0] m;
        for (int i = 0; i < NCLS; i++) begin
            m[i] = (rule_of(i).kind != TK_FATAL);
        end
        return m;
    endfunction

endpackage

// File: rtl/afl_classifier.sv
// Turns the event vector into capture enables and trap requests using
// the per-class rule table. Purely combinational; any mix of classes
// may be active in one cycle and their effects are OR-ed.
module afl_classifier
    import afl_pkg::*;
(
    input  logic [NCLS-1:0] evt_vec,
    input  logic            evt_instr,
    output logic            any_cap_pa,
    output logic            any_keep_e,
    output logic            any_keep_p,
    output logic            any_log_priv,
    output logic            req_instr,
    output logic            req_data,
    output logic            req_corr,
    output logic            req_fatal
);

    logic [NCLS-1:0] cls_instr;
    logic [NCLS-1:0] cls_data;
    logic [NCLS-1:0] cls_corr;
    logic [NCLS-1:0] cls_fatal;

    // One decoder per class, each applying its own fixed trap rule
    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        localparam rule_t RL = rule_of(g);
        always_comb begin
            cls_instr[g] = evt_vec[g] && (RL.kind == TK_DEFER_ID) && evt_instr;
            cls_data[g]  = evt_vec[g] && (((RL.kind == TK_DEFER_ID) && !evt_instr)
                                          || (RL.kind == TK_DEFER_D)
                                          || (RL.kind == TK_DISRUPT_D));
            cls_corr[g]  = evt_vec[g] && (RL.kind == TK_DISRUPT_C);
            cls_fatal[g] = evt_vec[g] && (RL.kind == TK_FATAL);
        end
    end

    // Merge per-class decisions into single enables and requests
    always_comb begin
        any_cap_pa   = |(evt_vec & mask_of(0));
        any_keep_e   = |(evt_vec & mask_of(1));
        any_keep_p   = |(evt_vec & mask_of(2));
        any_log_priv = |(evt_vec & mask_of(3));
        req_instr    = |cls_instr;
        req_data     = |cls_data;
        req_corr     = |cls_corr;
        req_fatal    = |cls_fatal;
    end

endmodule

// File: rtl/afl_regs.sv
// Fault address and status storage with first-error locking, write-one
// clear for non-fatal bits and the software read mux. Assumes a capture
// in the same cycle as a software write takes precedence.
module afl_regs
    import afl_pkg::*;
#(
    parameter int PA_W    = 41,
    parameter int PA_LSB  = 4,
    parameter int ESYND_W = 8,
    parameter int PSYND_W = 4,
    parameter int DATA_W  = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCLS-1:0]        evt_vec,
    input  logic [PA_W-1:0]        evt_pa,
    input  logic [ESYND_W-1:0]     evt_esynd,
    input  logic [PSYND_W-1:0]     evt_psynd,
    input  logic                   evt_priv,
    input  logic                   any_cap_pa,
    input  logic                   any_keep_e,
    input  logic                   any_keep_p,
    input  logic                   any_log_priv,
    input  logic                   reg_sel,
    input  logic                   reg_wr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic [NCLS-1:0]        status_q,
    output logic [PA_W-1:PA_LSB]   afar_q
);

    localparam int SR_USED = NCLS + 1 + ESYND_W + PSYND_W;
    localparam logic [NCLS-1:0] PA_LOCK   = mask_of(0);
    localparam logic [NCLS-1:0] E_LOCK    = mask_of(1);
    localparam logic [NCLS-1:0] P_LOCK    = mask_of(2);
    localparam logic [NCLS-1:0] PRIV_LOCK = mask_of(3);
    localparam logic [NCLS-1:0] CLR_OK    = sw_clear_mask();

    logic               priv_q;
    logic [ESYND_W-1:0] esynd_q;
    logic [PSYND_W-1:0] psynd_q;
    logic               wr_sr;
    logic               wr_ar;
    logic [NCLS-1:0]    clr_bits;
    logic [SR_USED-1:0] sr_view;

    // Decode software writes and the bits they may clear
    always_comb begin
        wr_sr    = reg_wr && !reg_sel;
        wr_ar    = reg_wr && reg_sel;
        clr_bits = wr_sr ? (reg_wdata[NCLS-1:0] & CLR_OK) : '0;
    end

    // Status bits: set by events, cleared by write-one, event wins
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_bits) | evt_vec;
    end

    // Address register: locked capture, else software write of bits 40:4
    always_ff @(posedge clk) begin
        if (!rst_n)                                        afar_q <= '0;
        else if (any_cap_pa && !(|(status_q & PA_LOCK)))   afar_q <= evt_pa[PA_W-1:PA_LSB];
        else if (wr_ar)                                    afar_q <= reg_wdata[PA_W-1:PA_LSB];
    end

    // Syndrome fields: each kept only while its owners are clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esynd_q <= '0;
            psynd_q <= '0;
        end else begin
            if (any_keep_e && !(|(status_q & E_LOCK))) esynd_q <= evt_esynd;
            if (any_keep_p && !(|(status_q & P_LOCK))) psynd_q <= evt_psynd;
        end
    end

    // Privilege bit: recorded by privilege-logging classes when unlocked
    always_ff @(posedge clk) begin
        if (!rst_n)                                              priv_q <= 1'b0;
        else if (any_log_priv && !(|(status_q & PRIV_LOCK)))     priv_q <= evt_priv;
    end

    // Read mux for the two software registers
    always_comb begin
        sr_view   = {psynd_q, esynd_q, priv_q, status_q};
        reg_rdata = '0;
        if (reg_sel) reg_rdata[PA_W-1:PA_LSB] = afar_q;
        else         reg_rdata[SR_USED-1:0]   = sr_view;
    end

endmodule

// File: rtl/afl_trap_out.sv
// Registers the trap and reset requests so that each output is a clean
// one-cycle pulse after the edge that samples the event.
module afl_trap_out (
    input  logic clk,
    input  logic rst_n,
    input  logic req_instr,
    input  logic req_data,
    input  logic req_corr,
    input  logic req_fatal,
    output logic trap_instr_err,
    output logic trap_data_err,
    output logic trap_corr_err,
    output logic por_req
);

    // Register the requests; they last as long as the event, one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_instr_err <= 1'b0;
            trap_data_err  <= 1'b0;
            trap_corr_err  <= 1'b0;
            por_req        <= 1'b0;
        end else begin
            trap_instr_err <= req_instr;
            trap_data_err  <= req_data;
            trap_corr_err  <= req_corr;
            por_req        <= req_fatal;
        end
    end

endmodule

// File: rtl/async_fault_log.sv
// Top of the asynchronous fault logger: classifier, register file and
// trap pulse stage. Assumes event inputs are synchronous to clk.
module async_fault_log
    import afl_pkg::*;
#(
    parameter int PA_W    = 41,
    parameter int PA_LSB  = 4,
    parameter int ESYND_W = 8,
    parameter int PSYND_W = 4,
    parameter int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCLS-1:0]    evt_vec,
    input  logic [PA_W-1:0]    evt_pa,
    input  logic [ESYND_W-1:0] evt_esynd,
    input  logic [PSYND_W-1:0] evt_psynd,
    input  logic               evt_instr,
    input  logic               evt_priv,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               trap_instr_err,
    output logic               trap_data_err,
    output logic               trap_corr_err,
    output logic               por_req
);

    logic                 any_cap_pa;
    logic                 any_keep_e;
    logic                 any_keep_p;
    logic                 any_log_priv;
    logic                 req_instr;
    logic                 req_data;
    logic                 req_corr;
    logic                 req_fatal;
    logic [NCLS-1:0]      status_q;
    logic [PA_W-1:PA_LSB] afar_q;

    afl_classifier u_cls (
        .evt_vec      (evt_vec),
        .evt_instr    (evt_instr),
        .any_cap_pa   (any_cap_pa),
        .any_keep_e   (any_keep_e),
        .any_keep_p   (any_keep_p),
        .any_log_priv (any_log_priv),
        .req_instr    (req_instr),
        .req_data     (req_data),
        .req_corr     (req_corr),
        .req_fatal    (req_fatal)
    );

    afl_regs #(
        .PA_W    (PA_W),
        .PA_LSB  (PA_LSB),
        .ESYND_W (ESYND_W),
        .PSYND_W (PSYND_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_vec      (evt_vec),
        .evt_pa       (evt_pa),
        .evt_esynd    (evt_esynd),
        .evt_psynd    (evt_psynd),
        .evt_priv     (evt_priv),
        .any_cap_pa   (any_cap_pa),
        .any_keep_e   (any_keep_e),
        .any_keep_p   (any_keep_p),
        .any_log_priv (any_log_priv),
        .reg_sel      (reg_sel),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .status_q     (status_q),
        .afar_q       (afar_q)
    );

    afl_trap_out u_trap (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_instr      (req_instr),
        .req_data       (req_data),
        .req_corr       (req_corr),
        .req_fatal      (req_fatal),
        .trap_instr_err (trap_instr_err),
        .trap_data_err  (trap_data_err),
        .trap_corr_err  (trap_corr_err),
        .por_req        (por_req)
    );

endmodule

// File: rtl/async_fault_log_chk.sv
// Property checker for the fault logger, bound onto the top module.
// Assumes the bound signals keep their top-level names.
module async_fault_log_chk #(
    parameter int NC     = 11,
    parameter int PA_W   = 41,
    parameter int PA_LSB = 4,
    parameter int DATA_W = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NC-1:0]        evt_vec,
    input logic [NC-1:0]        status_q,
    input logic [PA_W-1:PA_LSB] afar_q,
    input logic                 reg_sel,
    input logic                 reg_wr,
    input logic [DATA_W-1:0]    reg_rdata,
    input logic                 trap_corr_err,
    input logic                 por_req
);

    // R8
    fatal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[9] || status_q[10]) |=> (status_q[9] || status_q[10]));

    // R8
    por_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        por_req |-> $past(evt_vec[9] || evt_vec[10]));

    // R3
    corr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_corr_err |-> $past(evt_vec[1]));

    // R1
    afar_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_sel |-> (reg_rdata[DATA_W-1:PA_W] == '0 && reg_rdata[PA_LSB-1:0] == '0));

    // R9
    afar_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status_q[0] || status_q[1] || status_q[6] || status_q[7])
         && !$past(reg_wr && reg_sel)) |-> $stable(afar_q));

endmodule

bind async_fault_log async_fault_log_chk #(
    .NC     (11),
    .PA_W   (PA_W),
    .PA_LSB (PA_LSB),
    .DATA_W (DATA_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_vec       (evt_vec),
    .status_q      (status_q),
    .afar_q        (afar_q),
    .reg_sel       (reg_sel),
    .reg_wr        (reg_wr),
    .reg_rdata     (reg_rdata),
    .trap_corr_err (trap_corr_err),
    .por_req       (por_req)
);

// File: tb/async_fault_log_tb.sv
module async_fault_log_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] evt_vec;
    logic [40:0] evt_pa;
    logic [7:0]  evt_esynd;
    logic [3:0]  evt_psynd;
    logic        evt_instr;
    logic        evt_priv;
    logic        reg_sel;
    logic        reg_wr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        trap_instr_err;
    logic        trap_data_err;
    logic        trap_corr_err;
    logic        por_req;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    async_fault_log u_dut (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .evt_pa(evt_pa),
        .evt_esynd(evt_esynd), .evt_psynd(evt_psynd), .evt_instr(evt_instr),
        .evt_priv(evt_priv), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trap_instr_err(trap_instr_err), .trap_data_err(trap_data_err),
        .trap_corr_err(trap_corr_err), .por_req(por_req)
    );

    logic [3:0]  tr;   // {por, corr, data, instr} sampled after the event edge
    logic [63:0] sr;
    logic [63:0] ar;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [63:0] v);
        reg_sel = sel;
        #1;
        v = reg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; evt_vec = '0; reg_wr = 1'b0; reg_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply one event for one edge, sample the traps and both registers
    task automatic fire(input logic [10:0] v, input logic [40:0] pa, input logic [7:0] es,
                        input logic [3:0] ps, input logic ins, input logic prv);
        @(negedge clk);
        evt_vec = v; evt_pa = pa; evt_esynd = es; evt_psynd = ps;
        evt_instr = ins; evt_priv = prv;
        @(negedge clk);
        evt_vec = '0;
        tr = {por_req, trap_corr_err, trap_data_err, trap_instr_err};
        rd(1'b0, sr);
        rd(1'b1, ar);
    endtask

    task automatic wr(input logic sel, input logic [63:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [63:0] pa_view(input logic [40:0] pa);
        return {23'b0, pa[40:4], 4'b0};
    endfunction

    task automatic t_reset();
        do_reset();
        rd(1'b0, sr); rd(1'b1, ar);
        check("R11 status after reset", sr, 64'h0);
        check("R11 address after reset", ar, 64'h0);
        check("R11 traps after reset",
              {60'b0, por_req, trap_corr_err, trap_data_err, trap_instr_err}, 64'h0);
    endtask

    task automatic t_ue();
        fire(11'h001, 41'h1_2345_6789_AB, 8'hA5, 4'h3, 1'b1, 1'b1);
        check("R2 UE traps instr", {60'b0, tr}, 64'h1);
        check("R2 UE status/priv/esynd", sr, 64'h0000_0000_000A_5801);
        check("R1 R2 UE address", ar, pa_view(41'h1_2345_6789_AB));
        @(negedge clk);
        check("R11 pulse gone", {63'b0, trap_instr_err}, 64'h0);
        wr(1'b0, 64'h1FF);
        fire(11'h001, 41'h0_0000_1000_0F, 8'h11, 4'h0, 1'b0, 1'b0);
        check("R2 UE data trap", {60'b0, tr}, 64'h2);
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_ce();
        // priv currently 0 from previous UE; CE must not change it even with priv=1
        fire(11'h002, 41'h0_ABCD_0000_10, 8'h3C, 4'h0, 1'b0, 1'b1);
        check("R3 CE corr trap", {60'b0, tr}, 64'h4);
        check("R3 CE status no priv", sr, 64'h0000_0000_0003_C002);
        check("R3 CE address", ar, pa_view(41'h0_ABCD_0000_10));
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_parity();
        logic [63:0] prev_ar;
        prev_ar = ar;
        fire(11'h004, 41'h1_FFFF_FFFF_FF, 8'h00, 4'h9, 1'b1, 1'b1);
        check("R4 EDP instr trap", {60'b0, tr}, 64'h1);
        check("R4 EDP status", sr, 64'h0000_0000_0093_C804);
        check("R4 EDP address kept", ar, prev_ar);
        wr(1'b0, 64'h1FF);
        fire(11'h020, 41'h1_FFFF_FFFF_FF, 8'h00, 4'h6, 1'b0, 1'b0);
        check("R4 buffer parity data trap", {60'b0, tr}, 64'h2);
        check("R4 buffer parity status", sr, 64'h0000_0000_0063_C020);
        wr(1'b0, 64'h1FF);
        fire(11'h008, 41'h0, 8'h00, 4'h5, 1'b1, 1'b1);
        check("R5 writeback data trap", {60'b0, tr}, 64'h2);
        check("R5 writeback status", sr, 64'h0000_0000_0053_C008);
        wr(1'b0, 64'h1FF);
        fire(11'h010, 41'h0, 8'h00, 4'h7, 1'b1, 1'b1);
        check("R5 copyout no trap", {60'b0, tr}, 64'h0);
        check("R5 copyout status", sr, 64'h0000_0000_0073_C010);
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_bus();
        fire(11'h040, 41'h0_1111_2222_30, 8'hFF, 4'hF, 1'b1, 1'b1);
        check("R6 BERR trap", {60'b0, tr}, 64'h1);
        check("R6 BERR status syndromes kept", sr, 64'h0000_0000_0073_C840);
        check("R6 BERR address", ar, pa_view(41'h0_1111_2222_30));
        wr(1'b0, 64'h1FF);
        fire(11'h080, 41'h0_4444_5555_60, 8'hFF, 4'hF, 1'b0, 1'b0);
        check("R6 TO trap", {60'b0, tr}, 64'h2);
        check("R6 TO status", sr, 64'h0000_0000_0073_C080);
        wr(1'b0, 64'h1FF);
        fire(11'h100, 41'h0_7777_0000_00, 8'h00, 4'h0, 1'b1, 1'b1);
        check("R7 IVUE data only", {60'b0, tr}, 64'h2);
        check("R7 IVUE status", sr, 64'h0000_0000_0073_C900);
        check("R7 IVUE address kept", ar, pa_view(41'h0_4444_5555_60));
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_lock();
        fire(11'h001, 41'h0_AAAA_0000_00, 8'h12, 4'h0, 1'b0, 1'b0);
        fire(11'h040, 41'h0_BBBB_0000_00, 8'h00, 4'h0, 1'b0, 1'b1);
        check("R9 address locked", ar, pa_view(41'h0_AAAA_0000_00));
        fire(11'h002, 41'h0_CCCC_0000_00, 8'h34, 4'h0, 1'b0, 1'b0);
        check("R9 esynd and priv locked", sr, 64'h0000_0000_0071_2043);
        fire(11'h004, 41'h0, 8'h00, 4'h2, 1'b0, 1'b0);
        fire(11'h008, 41'h0, 8'h00, 4'hD, 1'b0, 1'b0);
        check("R9 psynd locked", sr[23:20], 64'h2);
        wr(1'b0, 64'h1FF);
        fire(11'h040, 41'h0_BBBB_0000_00, 8'h00, 4'h0, 1'b0, 1'b1);
        check("R9 capture after clear", ar, pa_view(41'h0_BBBB_0000_00));
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_collide();
        fire(11'h003, 41'h0_0101_0000_00, 8'h55, 4'h0, 1'b0, 1'b0);
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 64'h003; evt_vec = 11'h002;
        evt_pa = 41'h0_0202_0000_00;
        @(negedge clk);
        reg_wr = 1'b0; evt_vec = '0;
        rd(1'b0, sr);
        check("R10 same-cycle event keeps bit", sr[10:0], 64'h002);
        wr(1'b0, 64'h1FF);
        rd(1'b0, sr);
        check("R10 write-one clear", sr[10:0], 64'h0);
        wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(1'b1, ar);
        check("R1 write only bits 40:4", ar, 64'h0000_01FF_FFFF_FFF0);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = 64'h0; evt_vec = 11'h080;
        evt_pa = 41'h0_0303_0000_00;
        @(negedge clk);
        reg_wr = 1'b0; evt_vec = '0;
        rd(1'b1, ar);
        check("R1 capture beats write", ar, pa_view(41'h0_0303_0000_00));
        wr(1'b0, 64'h1FF);
    endtask

    task automatic t_fatal();
        fire(11'h200, 41'h0, 8'h00, 4'hB, 1'b0, 1'b0);
        check("R8 tag parity por", {60'b0, tr}, 64'h8);
        check("R8 tag parity psynd", {sr[23:20], sr[10:0]}, {4'hB, 11'h200});
        fire(11'h400, 41'h0, 8'h00, 4'h0, 1'b0, 1'b0);
        check("R8 address parity por", {60'b0, tr}, 64'h8);
        wr(1'b0, 64'h7FF);
        rd(1'b0, sr);
        check("R8 fatal not cleared", sr[10:0], 64'h600);
        do_reset();
        rd(1'b0, sr);
        check("R8 cleared by reset", sr, 64'h0);
    endtask

    initial begin
        rst_n = 1'b0; evt_vec = '0; evt_pa = '0; evt_esynd = '0; evt_psynd = '0;
        evt_instr = 1'b0; evt_priv = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        t_reset();
        t_ue();
        t_ce();
        t_parity();
        t_bus();
        t_lock();
        t_collide();
        t_fatal();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule